// File: doc/BRIEF.md
# Event-Routed Phase-Shifted PWM Generator

This block makes several PWM waveforms from one free-running up-counter and a bank of match registers. Each cycle the counter is compared with every active match value. A hit on a match raises that match's event. Each output has a set mask and a clear mask, one bit per event. Any selected event drives the output high or low on the next clock edge. Match 0 also acts as the period limit: when the counter reaches it, the counter returns to zero. The waveform period is therefore the limit value plus one cycle.

Phase relations between outputs come only from where the events are placed. For example, output 0 can be set at count 0 and cleared at half the period, while output 1 is set at a quarter period and cleared at three quarters. Output 1 then lags output 0 by 90 degrees at 50% duty. Software writes new match values into staging (reload) registers. While the counter runs, these values move to the active compare set only at the period wrap, so a change never cuts a cycle short. When one event both sets and clears an output, a per-output conflict field decides the result. A halt input freezes the counter and the outputs.

Top module: `pwm_evt_unit`

## Requirements
- R1: After reset the counter is 0 and all outputs are low. All reload values, masks and conflict fields are 0.
- R2: While `haltReq` is 1, the counter holds its value, no event takes effect and every output keeps its level.
- R3: While running, the counter advances by one per clock. On the edge where it equals active match 0, it goes to 0 instead, so the period is (match 0 + 1) cycles.
- R4: Event e is raised in a cycle where the running counter equals active match e. A match value of 0 therefore fires in the first cycle after each restart. The output responds on the clock edge that ends that cycle.
- R5: Output o goes high when any raised event has its bit set in set mask o, and goes low when any raised event has its bit set in clear mask o. Mask bit e stands for event e. With matches 0, P/2, P/4 and 3P/4 on events 1 to 4, output 0 (set by event 1, cleared by event 2) and output 1 (set by event 3, cleared by event 4) both run at 50% duty, with output 1 lagging by P/4 cycles.
- R6: While running, a write to a reload register reaches the active match set only on the wrap edge. The period in progress completes with the old values.
- R7: While halted, the active match set is loaded from the reload registers on every clock edge, so a configuration written while halted is in force on the first counting edge.
- R8: When one raised event hits both masks of an output, the 2-bit conflict field of that output decides the result: 0 keeps the level, 1 drives high, 2 drives low, 3 inverts.
- R9: Register writes (`wrEn` high at a clock edge) decode `wrAddr` as follows. Address e (0 to NUM_EVT-1) is reload match e. Address 8+o is set mask o. Address 16+o is clear mask o. Address 24+o is conflict field o, held in `wrData[1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| haltReq | input | 1 | 1 stops the counter and freezes outputs |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (5) | Register address |
| wrData | input | CNT_W (32) | Register write data |
| pwmOut | output | NUM_OUT (2) | PWM outputs |

## Verification
The outputs are registered one stage behind the compare. The level seen after edge k therefore reflects the count value held during cycle k. The first counting edge is the first edge at which `haltReq` is sampled low, and that edge evaluates count 0. A reload write lands on its edge but changes compare behaviour only after the next wrap edge, so the expected period switches at that wrap count. The driver computes each expected level from the period formulas and queues it before the edge it belongs to. The monitor pops one entry 1 ns after each edge, so every comparison uses exactly that edge's result.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  typedef enum logic [1:0] {
    CONF_HOLD   = 2'd0,
    CONF_SET    = 2'd1,
    CONF_CLEAR  = 2'd2,
    CONF_TOGGLE = 2'd3
  } conflictE;

  typedef struct packed {
    logic run;   // counter advances, events take effect
    logic wrap;  // counter returns to zero this edge
    logic load;  // active match set takes reload values this edge
  } ctrlStrobesT;

endpackage

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 5,
  parameter int NUM_OUT = 2,
  parameter int ADDR_W  = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [CNT_W-1:0]                  wrData,
  output logic [NUM_EVT-1:0][CNT_W-1:0]     reloadQ,
  output logic [NUM_OUT-1:0][NUM_EVT-1:0]   setMaskQ,
  output logic [NUM_OUT-1:0][NUM_EVT-1:0]   clrMaskQ,
  output conflictE [NUM_OUT-1:0]            confQ
);

  localparam int SET_BASE  = 8;
  localparam int CLR_BASE  = 16;
  localparam int CONF_BASE = 24;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ  <= '0;
      setMaskQ <= '0;
      clrMaskQ <= '0;
      for (int o = 0; o < NUM_OUT; o++) confQ[o] <= CONF_HOLD;
    end else if (wrEn) begin
      for (int e = 0; e < NUM_EVT; e++) begin
        if (wrAddr == ADDR_W'(e)) reloadQ[e] <= wrData;
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (wrAddr == ADDR_W'(SET_BASE + o))  setMaskQ[o] <= wrData[NUM_EVT-1:0];
        if (wrAddr == ADDR_W'(CLR_BASE + o))  clrMaskQ[o] <= wrData[NUM_EVT-1:0];
        if (wrAddr == ADDR_W'(CONF_BASE + o)) confQ[o]    <= conflictE'(wrData[1:0]);
      end
    end
  end

endmodule

// File: rtl/pwm_evt_ctrl.sv
module pwm_evt_ctrl
  import pwm_evt_pkg::*;
(
  input  logic        haltReq,
  input  logic        limitHit,
  output ctrlStrobesT strb
);

  always_comb begin
    strb.run  = ~haltReq;
    strb.wrap = ~haltReq & limitHit;
    // halted: track reload values; running: only at the wrap edge
    strb.load = haltReq | limitHit;
  end

endmodule

// File: rtl/pwm_evt_datapath.sv
module pwm_evt_datapath
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobesT                   strb,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] reloadQ,
  output logic [CNT_W-1:0]              cntQ,
  output logic [NUM_EVT-1:0][CNT_W-1:0] matchAct,
  output logic [NUM_EVT-1:0]            evtHit
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.wrap) begin
      cntQ <= '0;
    end else if (strb.run) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchAct <= '0;
    end else if (strb.load) begin
      matchAct <= reloadQ;
    end
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_cmp
    assign evtHit[e] = (cntQ == matchAct[e]);
  end

endmodule

// File: rtl/pwm_evt_outs.sv
module pwm_evt_outs
  import pwm_evt_pkg::*;
#(
  parameter int NUM_EVT = 5,
  parameter int NUM_OUT = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobesT                     strb,
  input  logic [NUM_EVT-1:0]              evtHit,
  input  logic [NUM_OUT-1:0][NUM_EVT-1:0] setMaskQ,
  input  logic [NUM_OUT-1:0][NUM_EVT-1:0] clrMaskQ,
  input  conflictE [NUM_OUT-1:0]          confQ,
  output logic [NUM_OUT-1:0]              pwmOut
);

  logic [NUM_EVT-1:0] evtFire;
  logic [NUM_OUT-1:0] nxtOut;

  assign evtFire = evtHit & {NUM_EVT{strb.run}};

  function automatic logic resolveLevel(input logic cur, input logic setHit,
                                        input logic clrHit, input conflictE mode);
    logic res;
    res = cur;
    if (setHit && clrHit) begin
      case (mode)
        CONF_HOLD:   res = cur;
        CONF_SET:    res = 1'b1;
        CONF_CLEAR:  res = 1'b0;
        CONF_TOGGLE: res = ~cur;
        default:     res = cur;
      endcase
    end else if (setHit) begin
      res = 1'b1;
    end else if (clrHit) begin
      res = 1'b0;
    end
    return res;
  endfunction

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_route
    logic setHit;
    logic clrHit;
    assign setHit    = |(evtFire & setMaskQ[o]);
    assign clrHit    = |(evtFire & clrMaskQ[o]);
    assign nxtOut[o] = resolveLevel(pwmOut[o], setHit, clrHit, confQ[o]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmOut <= '0;
    else       pwmOut <= nxtOut;
  end

endmodule

// File: rtl/pwm_evt_unit.sv
module pwm_evt_unit
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 5,
  parameter int NUM_OUT = 2,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               haltReq,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [NUM_OUT-1:0] pwmOut
);

  logic [NUM_EVT-1:0][CNT_W-1:0]   reloadQ;
  logic [NUM_OUT-1:0][NUM_EVT-1:0] setMaskQ;
  logic [NUM_OUT-1:0][NUM_EVT-1:0] clrMaskQ;
  conflictE [NUM_OUT-1:0]          confQ;
  ctrlStrobesT                     strb;
  logic [CNT_W-1:0]                cntQ;
  logic [NUM_EVT-1:0][CNT_W-1:0]   matchAct;
  logic [NUM_EVT-1:0]              evtHit;

  pwm_evt_regs #(
    .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .reloadQ(reloadQ), .setMaskQ(setMaskQ), .clrMaskQ(clrMaskQ), .confQ(confQ)
  );

  pwm_evt_ctrl ctrl_i (
    .haltReq(haltReq), .limitHit(evtHit[0]), .strb(strb)
  );

  pwm_evt_datapath #(
    .CNT_W(CNT_W), .NUM_EVT(NUM_EVT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadQ(reloadQ),
    .cntQ(cntQ), .matchAct(matchAct), .evtHit(evtHit)
  );

  pwm_evt_outs #(
    .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT)
  ) outs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .evtHit(evtHit),
    .setMaskQ(setMaskQ), .clrMaskQ(clrMaskQ), .confQ(confQ), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_evt_unit_chk.sv
module pwm_evt_unit_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 5,
  parameter int NUM_OUT = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          haltReq,
  input logic [CNT_W-1:0]              cntQ,
  input logic [NUM_EVT-1:0][CNT_W-1:0] matchAct,
  input logic [NUM_EVT-1:0][CNT_W-1:0] reloadQ,
  input logic [NUM_OUT-1:0]            pwmOut
);

  // R2
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> ($stable(pwmOut) && $stable(cntQ)));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReq && cntQ != matchAct[0]) |=> (cntQ == $past(cntQ) + CNT_W'(1)));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReq && cntQ == matchAct[0]) |=> (cntQ == '0));

  // R6
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReq && cntQ != matchAct[0]) |=> $stable(matchAct));

  // R7
  halt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> (matchAct == $past(reloadQ)));

endmodule

bind pwm_evt_unit pwm_evt_unit_chk #(
  .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT)
) chk_i (
  .clk(clk), .rstN(rstN), .haltReq(haltReq), .cntQ(cntQ),
  .matchAct(matchAct), .reloadQ(reloadQ), .pwmOut(pwmOut)
);

// File: tb/pwm_evt_unit_tb_top.sv
module pwm_evt_unit_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        haltReq = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  pwmOut;

  int nChecks = 0;
  int nErrors = 0;

  logic [1:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  pwm_evt_unit dut_i (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: pwmOut actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one queued expectation per clock edge, sampled 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(pwmOut === e, t, pwmOut, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  // driver: queue the level due after the coming edge, then pass that edge
  task automatic step(input logic [1:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    haltReq = 1'b1;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut === 2'b00, "R1 reset outputs low", pwmOut, 2'b00);
  endtask

  // quadrature set-up: period p, events 1..4 at 0, p/2, p/4, 3p/4 (R9 map)
  task automatic cfgQuad(input int p);
    wreg(5'd0, 32'(p - 1));
    wreg(5'd1, 32'd0);
    wreg(5'd2, 32'(p / 2));
    wreg(5'd3, 32'(p / 4));
    wreg(5'd4, 32'(3 * p / 4));
    wreg(5'd8,  32'b00010);   // out0 set by event 1
    wreg(5'd16, 32'b00100);   // out0 cleared by event 2
    wreg(5'd9,  32'b01000);   // out1 set by event 3
    wreg(5'd17, 32'b10000);   // out1 cleared by event 4
  endtask

  // expected levels after the k-th counting edge (k from 0)
  function automatic logic [1:0] quadExp(input int k, input int p);
    int c;
    logic a, b;
    c = k % p;
    a = (c < p / 2);
    b = (c >= p / 4) && (c < 3 * p / 4);
    return {b, a};
  endfunction

  initial begin
    int run;
    doReset();

    // Scenario A: quadrature, halt in the middle
    cfgQuad(8);
    for (int i = 0; i < 3; i++) step(2'b00, "R2 halted before start");
    run = 0;
    for (int i = 0; i < 30; i++) begin
      if (i >= 11 && i < 15) begin
        haltReq = 1'b1;
        step((run == 0) ? 2'b00 : quadExp(run - 1, 8), "R2 halt freezes outputs");
      end else begin
        haltReq = 1'b0;
        step(quadExp(run, 8), "R3 R4 R5 R7 quadrature period 8");
        run++;
      end
    end

    // Scenario B: reload staged mid-period, applied at wrap
    doReset();
    cfgQuad(8);
    haltReq = 1'b0;
    for (int i = 0; i < 44; i++) begin
      wrEn = 1'b0;
      case (i)
        9:  begin wrEn = 1'b1; wrAddr = 5'd0; wrData = 32'd15; end
        10: begin wrEn = 1'b1; wrAddr = 5'd2; wrData = 32'd8;  end
        11: begin wrEn = 1'b1; wrAddr = 5'd3; wrData = 32'd4;  end
        12: begin wrEn = 1'b1; wrAddr = 5'd4; wrData = 32'd12; end
        default: ;
      endcase
      step((i < 16) ? quadExp(i, 8) : quadExp(i - 16, 16), "R6 reload at wrap");
    end
    wrEn = 1'b0;

    // Scenario C1: conflicts, out0 mode clear, out1 mode hold
    doReset();
    wreg(5'd0, 32'd3);
    wreg(5'd1, 32'd0);
    wreg(5'd2, 32'd2);
    wreg(5'd3, 32'd100);
    wreg(5'd4, 32'd100);
    wreg(5'd8,  32'b00110);
    wreg(5'd16, 32'b00010);
    wreg(5'd9,  32'b00110);
    wreg(5'd17, 32'b00010);
    wreg(5'd24, 32'd2);
    wreg(5'd25, 32'd0);
    haltReq = 1'b0;
    for (int k = 0; k < 16; k++) begin
      logic a, b;
      a = ((k % 4) >= 2);
      b = (k >= 2);
      step({b, a}, "R8 R9 conflict clear/hold");
    end

    // Scenario C2: out0 mode toggle, out1 mode set
    doReset();
    wreg(5'd0, 32'd3);
    wreg(5'd1, 32'd0);
    wreg(5'd2, 32'd2);
    wreg(5'd3, 32'd100);
    wreg(5'd4, 32'd100);
    wreg(5'd8,  32'b00010);
    wreg(5'd16, 32'b00010);
    wreg(5'd9,  32'b00010);
    wreg(5'd17, 32'b00010);
    wreg(5'd24, 32'd3);
    wreg(5'd25, 32'd1);
    haltReq = 1'b0;
    for (int k = 0; k < 16; k++) begin
      logic a;
      a = (((k / 4) % 2) == 0);
      step({1'b1, a}, "R8 conflict toggle/set");
    end

    haltReq = 1'b1;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule